// File: doc/BRIEF.md
# Gated Two-Stage Serial Handshake Mailbox

This block passes single bits in both directions between a host computer and a game console. The console reaches it only through its controller port: a clock strobe, one general output line and one read line. Storage is a two-stage serial shift register. The console's strobe moves the first stage into the last stage and loads the first stage from the console's output line. The console's read line always shows the last stage.

The shift is gated by the inverse of the last stage. A one in the last stage freezes the register, so that bit serves as both the idle marker and the reply-valid marker. To send a bit, the host loads the first stage and then clears the last stage. The console sees its read line drop, and its next strobe brings the bit into view. To reply, the host clears both stages. The console then strobes in a one followed by its data bit, and the host reads the pair as a two-bit status value.

The console strobe is asynchronous to the host clock. It is synchronised and edge-detected inside the block, together with the console's data line.

Top module: `strobe_mailbox`

## Requirements
- R1: Reset (rstN low) sets the last stage to 1 and the first stage to 0, so hostStatus reads 2'b10 and padRead reads 1.
- R2: While the last stage is 1, console strobes have no effect: hostStatus keeps its value across any number of strobe pulses.
- R3: While the last stage is 0 and no host operation is active, each rising edge of padStrobe causes exactly one shift. The last stage takes the old first stage, and the first stage takes padData as it stood with the strobe. A strobe held high shifts only once.
- R4: hostLoadEn writes hostLoadBit into the first stage on the next clock edge and leaves the last stage unchanged.
- R5: hostSetLast sets the last stage to 1 on the next clock edge and leaves the first stage unchanged. It overrides hostClearLast.
- R6: hostClearAll sets both stages to 0 on the next clock edge and overrides every other host operation.
- R7: hostClearLast sets the last stage to 0 on the next clock edge and leaves the first stage unchanged.
- R8: A host operation in the cycle where a strobe edge would shift wins. That shift is dropped, not deferred.
- R9: hostStatus bit 1 is the last stage and bit 0 is the first stage. padRead always equals the last stage.
- R10: Host-to-console transfer: after loading bit d and clearing the last stage, padRead reads 0. One console strobe then makes padRead read d.
- R11: Console-to-host reply: from the cleared state, strobing in 1 and then d leaves hostStatus at {1,d}. Further strobes keep this value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| padStrobe | input | 1 | Console controller clock strobe, asynchronous |
| padData | input | 1 | Console general output line, serial data into the first stage |
| padRead | output | 1 | Console read line, shows the last stage |
| hostLoadEn | input | 1 | Host: load the first stage this cycle |
| hostLoadBit | input | 1 | Host: value for the first-stage load |
| hostSetLast | input | 1 | Host: set the last stage to 1 |
| hostClearLast | input | 1 | Host: clear the last stage to 0 |
| hostClearAll | input | 1 | Host: clear both stages |
| hostStatus | output | 2 | {last stage, first stage} |

## Verification
A vector table drives four kinds of traffic, and each is told apart by the stage pattern it leaves:
- a host-to-console send of a 1 and of a 0, which differ in padRead after the console strobe;
- a console reply of 0 and of 1, which gives 2'b10 against 2'b11;
- strobes with padData at both values while the register is frozen, which must leave the pattern untouched;
- host writes while the last stage is already 1.

Directed tests follow the table:
- a reset from a non-idle state;
- a strobe held high for many cycles, which must shift once rather than repeatedly;
- a host load landing in the exact cycle of a strobe's shift, which must suppress the shift rather than delay it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Per-cycle strobes from control to datapath.
  typedef struct packed {
    logic clearAll;
    logic loadFirst;
    logic loadBit;
    logic setLast;
    logic clearLast;
    logic shift;
    logic shiftIn;
  } mbox_ctrl_t;

  localparam int unsigned STAGE_COUNT = 2;

endpackage

// File: rtl/mbox_strobe_sync.sv
module mbox_strobe_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic padStrobe,
  input  logic padData,
  output logic strobeRise,
  output logic dataAtRise
);

  localparam int unsigned LANES = 2;
  localparam int unsigned LAST  = SYNC_STAGES - 1;

  // Lane 0 carries the strobe, lane 1 the data, so both see the same delay.
  logic [LANES-1:0] syncPipe [SYNC_STAGES];
  logic             strobePrev;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncPipe[s] <= '0;
          else       syncPipe[s] <= {padData, padStrobe};
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncPipe[s] <= '0;
          else       syncPipe[s] <= syncPipe[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobePrev <= 1'b0;
    else       strobePrev <= syncPipe[LAST][0];
  end

  assign strobeRise = syncPipe[LAST][0] & ~strobePrev;
  assign dataAtRise = syncPipe[LAST][1];

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic       hostLoadEn,
  input  logic       hostLoadBit,
  input  logic       hostSetLast,
  input  logic       hostClearLast,
  input  logic       hostClearAll,
  input  logic       strobeRise,
  input  logic       dataAtRise,
  input  logic       lastStage,
  output mbox_ctrl_t ctrl
);

  logic hostBusy;

  always_comb begin
    hostBusy = hostLoadEn | hostSetLast | hostClearLast | hostClearAll;

    ctrl           = '0;
    ctrl.clearAll  = hostClearAll;
    ctrl.loadFirst = hostLoadEn & ~hostClearAll;
    ctrl.loadBit   = hostLoadBit;
    ctrl.setLast   = hostSetLast & ~hostClearAll;
    ctrl.clearLast = hostClearLast & ~hostSetLast & ~hostClearAll;
    // Gated shift: frozen while the last stage holds one; host writes win.
    ctrl.shift     = strobeRise & ~lastStage & ~hostBusy;
    ctrl.shiftIn   = dataAtRise;
  end

endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  mbox_ctrl_t ctrl,
  output logic       firstStage,
  output logic       lastStage
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastStage  <= 1'b1;
      firstStage <= 1'b0;
    end else if (ctrl.clearAll) begin
      lastStage  <= 1'b0;
      firstStage <= 1'b0;
    end else if (ctrl.shift) begin
      lastStage  <= firstStage;
      firstStage <= ctrl.shiftIn;
    end else begin
      if (ctrl.loadFirst) firstStage <= ctrl.loadBit;
      if (ctrl.setLast)        lastStage <= 1'b1;
      else if (ctrl.clearLast) lastStage <= 1'b0;
    end
  end

endmodule

// File: rtl/strobe_mailbox.sv
module strobe_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       padStrobe,
  input  logic       padData,
  output logic       padRead,
  input  logic       hostLoadEn,
  input  logic       hostLoadBit,
  input  logic       hostSetLast,
  input  logic       hostClearLast,
  input  logic       hostClearAll,
  output logic [1:0] hostStatus
);

  logic       strobeRise;
  logic       dataAtRise;
  logic       firstStage;
  logic       lastStage;
  mbox_ctrl_t ctrl;

  mbox_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rstN       (rstN),
    .padStrobe  (padStrobe),
    .padData    (padData),
    .strobeRise (strobeRise),
    .dataAtRise (dataAtRise)
  );

  mbox_ctrl u_ctrl (
    .hostLoadEn    (hostLoadEn),
    .hostLoadBit   (hostLoadBit),
    .hostSetLast   (hostSetLast),
    .hostClearLast (hostClearLast),
    .hostClearAll  (hostClearAll),
    .strobeRise    (strobeRise),
    .dataAtRise    (dataAtRise),
    .lastStage     (lastStage),
    .ctrl          (ctrl)
  );

  mbox_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .firstStage (firstStage),
    .lastStage  (lastStage)
  );

  assign padRead    = lastStage;
  assign hostStatus = {lastStage, firstStage};

endmodule

// File: rtl/strobe_mailbox_checker.sv
module strobe_mailbox_checker (
  input logic       clk,
  input logic       rstN,
  input logic       hostLoadEn,
  input logic       hostLoadBit,
  input logic       hostSetLast,
  input logic       hostClearLast,
  input logic       hostClearAll,
  input logic [1:0] hostStatus
);

  logic anyHost;
  assign anyHost = hostLoadEn | hostSetLast | hostClearLast | hostClearAll;

  // R2: frozen while last stage is one and the host leaves it alone.
  p_frozen_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hostStatus[1] && !hostLoadEn && !hostClearLast && !hostClearAll) |=> $stable(hostStatus));

  // R3: without host writes, the last stage either holds or takes the old first stage.
  p_shift_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!anyHost && !hostStatus[1]) |=>
      ($stable(hostStatus) || hostStatus[1] == $past(hostStatus[0])));

  // R4
  p_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostLoadEn && !hostClearAll) |=> hostStatus[0] == $past(hostLoadBit));

  // R5
  p_setlast_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hostSetLast && !hostClearAll) |=> hostStatus[1]);

  // R6
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    hostClearAll |=> hostStatus == 2'b00);

endmodule

bind strobe_mailbox strobe_mailbox_checker u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .hostLoadEn    (hostLoadEn),
  .hostLoadBit   (hostLoadBit),
  .hostSetLast   (hostSetLast),
  .hostClearLast (hostClearLast),
  .hostClearAll  (hostClearAll),
  .hostStatus    (hostStatus)
);

// File: tb/strobe_mailbox_bench.sv
`timescale 1ns/1ps
module strobe_mailbox_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       padStrobe = 1'b0;
  logic       padData = 1'b0;
  logic       padRead;
  logic       hostLoadEn = 1'b0;
  logic       hostLoadBit = 1'b0;
  logic       hostSetLast = 1'b0;
  logic       hostClearLast = 1'b0;
  logic       hostClearAll = 1'b0;
  logic [1:0] hostStatus;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  strobe_mailbox u_strobe_mailbox (
    .clk(clk), .rstN(rstN), .padStrobe(padStrobe), .padData(padData),
    .padRead(padRead), .hostLoadEn(hostLoadEn), .hostLoadBit(hostLoadBit),
    .hostSetLast(hostSetLast), .hostClearLast(hostClearLast),
    .hostClearAll(hostClearAll), .hostStatus(hostStatus)
  );

  // Vector: [5:3] op, [2] bit (load value or padData), [1:0] expected {last,first}
  localparam logic [2:0] OP_LOAD = 3'd1, OP_SETL = 3'd2, OP_CLRL = 3'd3,
                         OP_CLRA = 3'd4, OP_STRB = 3'd5;
  localparam int NV = 22;
  localparam logic [5:0] VEC [NV] = '{
    {OP_STRB, 1'b1, 2'b10},  // R2 frozen at idle
    {OP_LOAD, 1'b1, 2'b11},  // R4
    {OP_STRB, 1'b0, 2'b11},  // R2
    {OP_CLRL, 1'b0, 2'b01},  // R7 / R10 send 1
    {OP_STRB, 1'b0, 2'b10},  // R10 console now reads 1
    {OP_STRB, 1'b1, 2'b10},  // R2
    {OP_CLRA, 1'b0, 2'b00},  // R6
    {OP_STRB, 1'b1, 2'b01},  // R3 / R11 marker
    {OP_STRB, 1'b0, 2'b10},  // R11 reply 0
    {OP_STRB, 1'b1, 2'b10},  // R11 held
    {OP_CLRA, 1'b0, 2'b00},  // R6
    {OP_STRB, 1'b1, 2'b01},  // R3
    {OP_STRB, 1'b1, 2'b11},  // R11 reply 1
    {OP_STRB, 1'b0, 2'b11},  // R11 held
    {OP_SETL, 1'b0, 2'b11},  // R5
    {OP_CLRA, 1'b0, 2'b00},  // R6
    {OP_SETL, 1'b0, 2'b10},  // R5 first untouched
    {OP_LOAD, 1'b0, 2'b10},  // R4
    {OP_CLRL, 1'b0, 2'b00},  // R10 send 0
    {OP_STRB, 1'b1, 2'b01},  // R10 console reads 0
    {OP_LOAD, 1'b0, 2'b00},  // R4 last untouched
    {OP_SETL, 1'b0, 2'b10}   // R5
  };

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if (hostStatus !== exp || padRead !== exp[1]) begin
      errors++;
      $display("FAIL %s: status=%b padRead=%b expected status=%b padRead=%b",
               req, hostStatus, padRead, exp, exp[1]);
    end
  endtask

  task automatic strobePulse(input logic d);
    @(negedge clk);
    padData = d; padStrobe = 1'b1;
    repeat (4) @(negedge clk);
    padStrobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic hostOp(input logic [2:0] op, input logic b);
    @(negedge clk);
    hostLoadEn    = (op == OP_LOAD);
    hostLoadBit   = b;
    hostSetLast   = (op == OP_SETL);
    hostClearLast = (op == OP_CLRL);
    hostClearAll  = (op == OP_CLRA);
    @(negedge clk);
    hostLoadEn = 1'b0; hostSetLast = 1'b0; hostClearLast = 1'b0; hostClearAll = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset idle", 2'b10);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", 2'b10);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][5:3] == OP_STRB) strobePulse(VEC[i][2]);
      else hostOp(VEC[i][5:3], VEC[i][2]);
      check($sformatf("R9 vector %0d", i), VEC[i][1:0]);
    end

    // R3: held strobe shifts exactly once
    hostOp(OP_CLRA, 1'b0);
    @(negedge clk);
    padData = 1'b1; padStrobe = 1'b1;
    repeat (12) @(negedge clk);
    check("R3 held strobe single shift", 2'b01);
    padStrobe = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 after release", 2'b01);

    // R8: host load coincides with the shift cycle; shift dropped
    hostOp(OP_CLRA, 1'b0);
    hostOp(OP_LOAD, 1'b1);
    @(negedge clk);
    padData = 1'b0; padStrobe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    hostLoadEn = 1'b1; hostLoadBit = 1'b1;
    @(negedge clk);
    hostLoadEn = 1'b0;
    check("R8 host wins shift cycle", 2'b01);
    repeat (4) @(negedge clk);
    padStrobe = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 shift not deferred", 2'b01);

    // R6 over R5: clear-all wins
    @(negedge clk);
    hostSetLast = 1'b1; hostClearAll = 1'b1; hostLoadEn = 1'b1; hostLoadBit = 1'b1;
    @(negedge clk);
    hostSetLast = 1'b0; hostClearAll = 1'b0; hostLoadEn = 1'b0;
    check("R6 clear-all overrides", 2'b00);

    // R5 over R7
    @(negedge clk);
    hostSetLast = 1'b1; hostClearLast = 1'b1;
    @(negedge clk);
    hostSetLast = 1'b0; hostClearLast = 1'b0;
    check("R5 set overrides clear-last", 2'b10);

    // R1: reset from a non-idle state
    hostOp(OP_LOAD, 1'b1);
    hostOp(OP_CLRL, 1'b0);
    check("R7 pre-reset state", 2'b01);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset from busy", 2'b10);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule